// File: doc/BRIEF.md
# Vector Gather Load Engine

This unit fetches eight 32-bit elements from scattered byte addresses and packs them into one 256-bit result. A caller gives a base byte address, a vector of signed 32-bit lane offsets, a 2-bit scale code, a displacement with a width selector, a per-lane enable vector and a fallback vector. For every enabled lane the unit forms a byte address and reads four bytes through a word-wide memory read port. The lane's data may start at any byte, so an element that spans two words takes two reads, and the bytes are joined in little-endian order.

Lanes are served one at a time, lowest lane first. Each served lane has its enable element cleared. Lanes that are not enabled keep their fallback value and cause no memory traffic. When every lane is finished the unit raises a one-cycle completion pulse. At that point the result is valid and the returned enable vector is all zeros.

Top module: `vgather_unit`

## Requirements
- R1: The byte address of lane i is base + (offset_i sign-extended) × 2^scale_code + extended displacement, taken modulo 2^32. Lane i's offset is idx_vec[32i+31:32i]. scale_code 0,1,2,3 selects the multipliers 1,2,4,8. The address is a byte address, not an element index.
- R2: disp_sel selects the displacement width. 0 means no displacement (zero). 1 sign-extends disp[7:0]. 2 sign-extends disp[15:0]. 3 uses all 32 bits of disp.
- R3: Lane i is enabled when lane_en_in[32i+31] is 1. The other bits of that element are ignored. A lane that is not enabled returns fill_in[32i+31:32i] and issues no memory read.
- R4: Enabled lanes are read strictly in ascending lane order. All reads for one lane finish before any read for the next lane.
- R5: If the address is word aligned (addr[1:0]==0), the lane needs one read at that address. Otherwise the unit reads word floor(addr/4)*4 and then the next word (+4, modulo 2^32). The element is bytes addr..addr+3, with the byte at addr placed in bits 7:0.
- R6: rd_addr is always word aligned. While rd_valid is high and rd_ready is low, rd_valid stays high and rd_addr does not change. rd_data is taken in the cycle after a request is accepted (rd_valid and rd_ready both high).
- R7: done is high for exactly one cycle per gather. While done is high, lane_en_out is all zeros and result holds the complete gathered vector.
- R8: A start seen while busy is high has no effect on the gather in progress: its result, its reads and its completion are unchanged.
- R9: If no lane is enabled, done is high in the cycle right after the start edge, result equals fill_in, and no read is issued.
- R10: Lane i's element appears in result[32i+31:32i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a gather (accepted only when idle) |
| base_addr | input | 32 | Base byte address |
| idx_vec | input | 256 | Eight signed 32-bit lane offsets |
| scale_code | input | 2 | Offset multiplier code (1,2,4,8) |
| disp | input | 32 | Displacement value |
| disp_sel | input | 2 | Displacement width select |
| lane_en_in | input | 256 | Per-lane enable elements (bit 31 of each) |
| fill_in | input | 256 | Values for lanes that are not enabled |
| busy | output | 1 | Gather in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 256 | Gathered vector |
| lane_en_out | output | 256 | Remaining enable elements |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory read request accepted |
| rd_addr | output | 32 | Word-aligned read byte address |
| rd_data | input | 32 | Read data, one cycle after acceptance |

## Verification
The bench builds the unit with its default of eight lanes, which is the full 256-bit vector. With eight lanes a single gather can mix aligned and straddling lanes, scattered enable patterns, and the worst case of sixteen reads. A word-addressed memory model with random back-pressure on rd_ready exercises the request hold rule. Directed cases also reach address wrap past 2^32, negative offsets and every displacement width.

// File: rtl/vgather_pkg.sv
package vgather_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RESP} gstate_t;

  // Extend the displacement according to its width selector.
  function automatic logic [WORD_W-1:0] disp_extend(input logic [WORD_W-1:0] d,
                                                    input logic [1:0] sel);
    logic [WORD_W-1:0] r;
    case (sel)
      2'd0:    r = '0;
      2'd1:    r = {{(WORD_W-8){d[7]}}, d[7:0]};
      2'd2:    r = {{(WORD_W-16){d[15]}}, d[15:0]};
      default: r = d;
    endcase
    return r;
  endfunction

  // Byte address of one lane; 32-bit wrap is implicit.
  function automatic logic [WORD_W-1:0] lane_address(input logic [WORD_W-1:0] base,
                                                     input logic [WORD_W-1:0] off,
                                                     input logic [1:0] sc,
                                                     input logic [WORD_W-1:0] dext);
    return base + (off << sc) + dext;
  endfunction

  // Pick four bytes starting at byte 'ofs' of the pair {hi, lo}.
  function automatic logic [WORD_W-1:0] splice_element(input logic [WORD_W-1:0] lo,
                                                       input logic [WORD_W-1:0] hi,
                                                       input logic [1:0] ofs);
    logic [2*WORD_W-1:0] pair;
    pair = {hi, lo} >> {ofs, 3'b000};
    return pair[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/vgather_addr.sv
module vgather_addr
  import vgather_pkg::*;
(
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] off,
  input  logic [1:0]        scale_code,
  input  logic [WORD_W-1:0] disp_ext,
  output logic [WORD_W-1:0] byte_addr,
  output logic [WORD_W-1:0] word_lo,
  output logic [WORD_W-1:0] word_hi,
  output logic [1:0]        byte_ofs,
  output logic              straddle
);
  always_comb begin
    byte_addr = lane_address(base, off, scale_code, disp_ext);
    word_lo   = {byte_addr[WORD_W-1:2], 2'b00};
    word_hi   = word_lo + WORD_W'(4);
    byte_ofs  = byte_addr[1:0];
    straddle  = (byte_addr[1:0] != 2'b00);
  end
endmodule

// File: rtl/vgather_pick.sv
module vgather_pick #(
  parameter int LANES = 8,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] pending,
  output logic             any,
  output logic [LW-1:0]    first
);
  always_comb begin
    any   = |pending;
    first = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) first = LW'(i);
    end
  end
endmodule

// File: rtl/vgather_merge.sv
module vgather_merge
  import vgather_pkg::*;
(
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] rd_word,
  input  logic [1:0]        byte_ofs,
  input  logic              straddle,
  output logic [WORD_W-1:0] element
);
  always_comb begin
    if (straddle) element = splice_element(lo_word, rd_word, byte_ofs);
    else          element = rd_word;
  end
endmodule

// File: rtl/vgather_unit.sv
module vgather_unit
  import vgather_pkg::*;
#(
  parameter int LANES = 8,
  localparam int VEC_W = LANES * WORD_W,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] base_addr,
  input  logic [VEC_W-1:0]  idx_vec,
  input  logic [1:0]        scale_code,
  input  logic [WORD_W-1:0] disp,
  input  logic [1:0]        disp_sel,
  input  logic [VEC_W-1:0]  lane_en_in,
  input  logic [VEC_W-1:0]  fill_in,
  output logic              busy,
  output logic              done,
  output logic [VEC_W-1:0]  result,
  output logic [VEC_W-1:0]  lane_en_out,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data
);
  gstate_t           state;
  logic [LW-1:0]     cur_lane;
  logic              second;
  logic [WORD_W-1:0] lo_word;
  logic [WORD_W-1:0] op_base;
  logic [VEC_W-1:0]  op_idx;
  logic [1:0]        op_scale;
  logic [WORD_W-1:0] op_disp;
  logic [LANES-1:0]  pending;
  logic [VEC_W-1:0]  result_q;
  logic [VEC_W-1:0]  mask_q;
  logic              done_q;

  // Named internal events (observed by the checker)
  logic              op_accept;
  logic              req_fire;
  logic              lane_commit;
  logic [LW-1:0]     commit_lane;

  logic [LANES-1:0]  en_in;
  logic [LANES-1:0]  lane_onehot;
  logic [LANES-1:0]  pick_vec;
  logic              pick_any;
  logic [LW-1:0]     pick_first;

  logic [WORD_W-1:0] cur_off;
  logic [WORD_W-1:0] byte_addr;
  logic [WORD_W-1:0] word_lo;
  logic [WORD_W-1:0] word_hi;
  logic [1:0]        byte_ofs;
  logic              straddle;
  logic [WORD_W-1:0] element;
  logic              need_second;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_en
      assign en_in[g] = lane_en_in[g*WORD_W + WORD_W - 1];
    end
  endgenerate

  assign lane_onehot = LANES'(1) << cur_lane;
  assign pick_vec    = (state == ST_IDLE) ? en_in : (pending & ~lane_onehot);
  assign cur_off     = op_idx[cur_lane*WORD_W +: WORD_W];

  vgather_pick #(.LANES(LANES)) u_pick (
    .pending (pick_vec),
    .any     (pick_any),
    .first   (pick_first)
  );

  vgather_addr u_addr (
    .base       (op_base),
    .off        (cur_off),
    .scale_code (op_scale),
    .disp_ext   (op_disp),
    .byte_addr  (byte_addr),
    .word_lo    (word_lo),
    .word_hi    (word_hi),
    .byte_ofs   (byte_ofs),
    .straddle   (straddle)
  );

  vgather_merge u_merge (
    .lo_word  (lo_word),
    .rd_word  (rd_data),
    .byte_ofs (byte_ofs),
    .straddle (straddle),
    .element  (element)
  );

  assign op_accept   = start && (state == ST_IDLE);
  assign req_fire    = (state == ST_REQ) && rd_ready;
  assign need_second = straddle && !second;
  assign lane_commit = (state == ST_RESP) && !need_second;
  assign commit_lane = cur_lane;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_lane <= '0;
      second   <= 1'b0;
      lo_word  <= '0;
      op_base  <= '0;
      op_idx   <= '0;
      op_scale <= '0;
      op_disp  <= '0;
      pending  <= '0;
      result_q <= '0;
      mask_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (op_accept) begin
            op_base  <= base_addr;
            op_idx   <= idx_vec;
            op_scale <= scale_code;
            op_disp  <= disp_extend(disp, disp_sel);
            pending  <= en_in;
            result_q <= fill_in;
            second   <= 1'b0;
            if (pick_any) begin
              mask_q   <= lane_en_in;
              cur_lane <= pick_first;
              state    <= ST_REQ;
            end else begin
              mask_q <= '0;
              done_q <= 1'b1;
            end
          end
        end
        ST_REQ: begin
          if (req_fire) state <= ST_RESP;
        end
        ST_RESP: begin
          if (need_second) begin
            lo_word <= rd_data;
            second  <= 1'b1;
            state   <= ST_REQ;
          end else begin
            result_q[cur_lane*WORD_W +: WORD_W] <= element;
            mask_q[cur_lane*WORD_W +: WORD_W]   <= '0;
            pending[cur_lane]                   <= 1'b0;
            second                              <= 1'b0;
            if (pick_any) begin
              cur_lane <= pick_first;
              state    <= ST_REQ;
            end else begin
              mask_q <= '0;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign done        = done_q;
  assign result      = result_q;
  assign lane_en_out = mask_q;
  assign rd_valid    = (state == ST_REQ);
  assign rd_addr     = second ? word_hi : word_lo;
endmodule

// File: rtl/vgather_checker.sv
module vgather_checker
  import vgather_pkg::*;
#(
  parameter int LANES = 8,
  localparam int VEC_W = LANES * WORD_W,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [VEC_W-1:0]  lane_en_out,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [WORD_W-1:0] rd_addr,
  input logic              op_accept,
  input logic              lane_commit,
  input logic [LW-1:0]     commit_lane
);
  logic          seen;
  logic [LW-1:0] last_lane;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      last_lane <= '0;
    end else if (op_accept) begin
      seen <= 1'b0;
    end else if (lane_commit) begin
      seen      <= 1'b1;
      last_lane <= commit_lane;
    end
  end

  assert_word_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr[1:0] == 2'b00));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lane_en_out == '0));

  assert_no_reaccept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !op_accept);

  assert_req_in_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_commit && seen) |-> (commit_lane > last_lane));
endmodule

bind vgather_unit vgather_checker #(.LANES(LANES)) u_vgather_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .lane_en_out (lane_en_out),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_addr     (rd_addr),
  .op_accept   (op_accept),
  .lane_commit (lane_commit),
  .commit_lane (commit_lane)
);

// File: tb/test_vgather_unit.sv
module test_vgather_unit;
  localparam int LANES = 8;
  localparam int VW = LANES * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   base_addr = '0;
  logic [VW-1:0] idx_vec = '0;
  logic [1:0]    scale_code = '0;
  logic [31:0]   disp = '0;
  logic [1:0]    disp_sel = '0;
  logic [VW-1:0] lane_en_in = '0;
  logic [VW-1:0] fill_in = '0;
  logic          busy, done, rd_valid;
  logic [VW-1:0] result, lane_en_out;
  logic          rd_ready = 1'b0;
  logic [31:0]   rd_addr;
  logic [31:0]   rd_data = '0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  vgather_unit #(.LANES(LANES)) i_vgather_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .idx_vec(idx_vec), .scale_code(scale_code), .disp(disp), .disp_sel(disp_sel),
    .lane_en_in(lane_en_in), .fill_in(fill_in), .busy(busy), .done(done),
    .result(result), .lane_en_out(lane_en_out), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Memory contents as a function of the word address
  function automatic logic [31:0] mem_word(input logic [31:0] wa);
    return ((wa ^ 32'hA5C3_0F17) * 32'h0101_0107) + 32'h1357_9BDF;
  endfunction

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [31:0] w;
    w = mem_word({a[31:2], 2'b00});
    return w[8*a[1:0] +: 8];
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [31:0] ix,
                                           input logic [1:0] sc, input logic [31:0] d,
                                           input logic [1:0] ds);
    logic signed [31:0] sd;
    logic signed [31:0] six;
    int mult;
    six = ix;
    mult = 1;
    for (int k = 0; k < 3; k++) if (sc > k) mult = mult * 2;
    case (ds)
      2'd0: sd = 0;
      2'd1: sd = $signed(d[7:0]);
      2'd2: sd = $signed(d[15:0]);
      default: sd = $signed(d);
    endcase
    return b + 32'(six * mult) + 32'(sd);
  endfunction

  logic        log_clr = 1'b0;
  logic [31:0] log_a [0:31];
  int          log_n = 0;

  always @(posedge clk) begin
    if (log_clr) log_n <= 0;
    else if (rd_valid && rd_ready) begin
      rd_data <= mem_word(rd_addr);
      if (log_n < 32) log_a[log_n] <= rd_addr;
      log_n <= log_n + 1;
    end
  end

  always @(negedge clk) rd_ready <= (($urandom % 4) != 0);

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] b, input logic [VW-1:0] ix, input logic [1:0] sc,
                        input logic [31:0] d, input logic [1:0] ds,
                        input logic [VW-1:0] en, input logic [VW-1:0] fl, input bit poke);
    logic [VW-1:0] exp_res;
    logic [31:0]   exp_log [0:31];
    int            exp_n;
    int            cyc;
    bit            log_ok;
    exp_res = fl;
    exp_n = 0;
    for (int i = 0; i < LANES; i++) begin
      if (en[32*i+31]) begin
        logic [31:0] a;
        a = exp_addr(b, ix[32*i +: 32], sc, d, ds);
        exp_res[32*i +: 32] = {mem_byte(a + 3), mem_byte(a + 2), mem_byte(a + 1), mem_byte(a)};
        exp_log[exp_n] = a & 32'hFFFF_FFFC;
        exp_n++;
        if (a[1:0] != 2'b00) begin
          exp_log[exp_n] = (a & 32'hFFFF_FFFC) + 32'd4;
          exp_n++;
        end
      end
    end
    @(negedge clk);
    log_clr = 1'b1;
    base_addr = b; idx_vec = ix; scale_code = sc; disp = d; disp_sel = ds;
    lane_en_in = en; fill_in = fl; start = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
    start = 1'b0;
    if (poke && !done) begin
      // R8: a second start with other operands while busy
      base_addr = ~b; lane_en_in = ~en; fill_in = ~fl; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R7 done seen", VW'(done), VW'(1));
    if (en == '0 || exp_n == 0)
      chk(cyc == 0, "R9 done next cycle", VW'(cyc), VW'(0));
    chk(result == exp_res, poke ? "R8 result" : "R1,R2,R3,R5,R10 result", result, exp_res);
    chk(lane_en_out == '0, "R7 mask cleared", lane_en_out, '0);
    chk(log_n == exp_n, "R3,R5 read count", VW'(log_n), VW'(exp_n));
    log_ok = (log_n == exp_n);
    for (int k = 0; k < exp_n && k < 32; k++)
      if (log_ok && log_a[k] != exp_log[k]) begin
        log_ok = 0;
        chk(0, "R4,R5,R6 read order", VW'(log_a[k]), VW'(exp_log[k]));
      end
    @(negedge clk);
    chk(done == 1'b0, "R7 single pulse", VW'(done), VW'(0));
  endtask

  function automatic logic [VW-1:0] all_en();
    logic [VW-1:0] v;
    for (int i = 0; i < LANES; i++) v[32*i +: 32] = 32'h8000_0000;
    return v;
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < LANES; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VW-1:0] ix;
    logic [VW-1:0] en;
    void'($urandom(32'd7391));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !rd_valid, "R7 reset idle", VW'({busy, done, rd_valid}), '0);

    // R1 R10: aligned lanes, multiplier 4, no displacement
    for (int i = 0; i < LANES; i++) ix[32*i +: 32] = 32'(i);
    run_op(32'h0000_1000, ix, 2'd2, 32'h0, 2'd0, all_en(), rand_vec(), 0);
    // R5 R2: multiplier 1 with odd offsets and a negative 8-bit displacement
    for (int i = 0; i < LANES; i++) ix[32*i +: 32] = 32'(3 * i + 1);
    run_op(32'h0000_2000, ix, 2'd0, 32'hDEAD_BEFE, 2'd1, all_en(), rand_vec(), 0);
    // R1 R3: negative offsets, multiplier 8, 16-bit displacement, partial enables
    for (int i = 0; i < LANES; i++) ix[32*i +: 32] = -32'(5 * i + 2);
    en = rand_vec();
    for (int i = 0; i < LANES; i++) en[32*i +: 32] = (i % 3 == 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
    run_op(32'h0001_0000, ix, 2'd3, 32'h0000_8001, 2'd2, en, rand_vec(), 0);
    // R5 R1: wrap past 2^32 on a straddling lane
    ix = '0;
    en = '0; en[31] = 1'b1;
    run_op(32'hFFFF_FFFE, ix, 2'd0, 32'h0, 2'd0, en, rand_vec(), 0);
    // R9: nothing enabled (other mask bits set)
    en = '0;
    for (int i = 0; i < LANES; i++) en[32*i +: 31] = 31'h7FFF_FFFF;
    run_op(32'h0000_3000, rand_vec(), 2'd1, 32'h0, 2'd0, en, rand_vec(), 0);
    // R2: 32-bit displacement, multiplier 2
    run_op(32'h0040_0000, rand_vec() & {LANES{32'h0000_FFFF}}, 2'd1, 32'h1234_5677, 2'd3,
           all_en(), rand_vec(), 0);
    // R8: start pulse while busy
    run_op(32'h0000_5001, rand_vec(), 2'd0, 32'h0, 2'd0, all_en(), rand_vec(), 1);
    // Random mix
    for (int t = 0; t < 40; t++)
      run_op($urandom, rand_vec(), 2'($urandom), $urandom, 2'($urandom), rand_vec(),
             rand_vec(), ($urandom % 5) == 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule